// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small parallel-in, parallel-out register that can hold its contents, move them one place toward the most significant end, move them one place toward the least significant end, or take a whole new word from its parallel inputs. Two select lines choose the action. Every action takes effect on the rising clock edge. An active-low clear forces the whole register to zero at once, without waiting for the clock.

Serial data enters at one end of the word or the other. A right shift pulls the right serial input into the most significant bit. A left shift pulls the left serial input into the least significant bit. A rotating register is built outside the block by wiring one end of the output back to the matching serial input. The word width is a parameter and defaults to four bits. Bit WIDTH-1 is the most significant stage, QA, and bit 0 is the least significant stage, QD.

Top module: `uni_shreg`

## Requirements
- R1: While clr_n is low, q is all zeros as soon as clr_n falls, whatever the clock, the selects and the data inputs are doing.
- R2: With {sel0,sel1} = 2'b00, a rising edge leaves q unchanged.
- R3: With {sel0,sel1} = 2'b10, a rising edge shifts right: q[WIDTH-1] takes ser_rt and each q[i] takes the old q[i+1].
- R4: With {sel0,sel1} = 2'b01, a rising edge shifts left: q[0] takes ser_lf and each q[i] takes the old q[i-1].
- R5: With {sel0,sel1} = 2'b11, a rising edge loads par_d into q bit for bit, so par_d[WIDTH-1] (A) goes to QA and par_d[0] (D) goes to QD.
- R6: q changes only on a rising clock edge or on clear. Input changes between edges have no effect on q until the next rising edge.
- R7: The serial input that the selected mode does not use has no effect on the result. ser_lf does not matter in a right shift, and ser_rt does not matter in a left shift, a hold or a load.
- R8: With q preset to 4'b0110 and q[0] fed back to ser_rt under right-shift mode, q steps through 0011, 1001, 1100, 0110 and so repeats every four clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every mode acts on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel0 | input | 1 | Mode select, high-order bit of the mode code |
| sel1 | input | 1 | Mode select, low-order bit of the mode code |
| ser_rt | input | 1 | Serial input that enters QA during a right shift |
| ser_lf | input | 1 | Serial input that enters QD during a left shift |
| par_d | input | WIDTH | Parallel data; bit WIDTH-1 is A, bit 0 is D |
| q | output | WIDTH | Register contents; bit WIDTH-1 is QA, bit 0 is QD |

## Verification
Each hold, shift or load result appears in q at the first rising edge after its inputs are applied. There is exactly one register stage, so the bench drives inputs on the falling edge and compares q against its queue-based model at the next falling edge. Clear is different: its result is due at once, with no edge. The bench lowers clr_n in the middle of a phase and samples q one nanosecond later, before any rising edge comes. For R6 the bench changes the inputs between edges and samples q before the next rising edge, where it must still hold the old value.

// File: rtl/uni_shreg_pkg.sv
package uni_shreg_pkg;
   // mode code is {sel0, sel1}
   typedef enum logic [1:0] {
      MODE_HOLD  = 2'b00,
      MODE_LEFT  = 2'b01,
      MODE_RIGHT = 2'b10,
      MODE_LOAD  = 2'b11
   } shr_mode_e;
endpackage

// File: rtl/uni_shreg_dec.sv
module uni_shreg_dec
   import uni_shreg_pkg::*;
(
   input  logic      sel0,
   input  logic      sel1,
   output shr_mode_e mode
);
   always_comb begin
      unique case ({sel0, sel1})
         2'b00:   mode = MODE_HOLD;
         2'b01:   mode = MODE_LEFT;
         2'b10:   mode = MODE_RIGHT;
         default: mode = MODE_LOAD;
      endcase
   end
endmodule

// File: rtl/uni_shreg_cell.sv
module uni_shreg_cell
   import uni_shreg_pkg::*;
(
   input  logic      clk,
   input  logic      clr_n,
   input  shr_mode_e mode,
   input  logic      from_hi,   // neighbour toward MSB (right-shift source)
   input  logic      from_lo,   // neighbour toward LSB (left-shift source)
   input  logic      par,
   output logic      q_o
);
   logic nxt;

   always_comb begin
      unique case (mode)
         MODE_HOLD:  nxt = q_o;
         MODE_LEFT:  nxt = from_lo;
         MODE_RIGHT: nxt = from_hi;
         default:    nxt = par;
      endcase
   end

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q_o <= 1'b0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/uni_shreg.sv
module uni_shreg
   import uni_shreg_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             sel0,
   input  logic             sel1,
   input  logic             ser_rt,
   input  logic             ser_lf,
   input  logic [WIDTH-1:0] par_d,
   output logic [WIDTH-1:0] q
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("uni_shreg: WIDTH must be at least 2");
   end

   shr_mode_e mode;

   uni_shreg_dec u_dec (
      .sel0 (sel0),
      .sel1 (sel1),
      .mode (mode)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic hi_src, lo_src;
      if (i == MSB) begin : g_top
         assign hi_src = ser_rt;
      end else begin : g_mid_hi
         assign hi_src = q[i+1];
      end
      if (i == 0) begin : g_bot
         assign lo_src = ser_lf;
      end else begin : g_mid_lo
         assign lo_src = q[i-1];
      end
      uni_shreg_cell u_cell (
         .clk     (clk),
         .clr_n   (clr_n),
         .mode    (mode),
         .from_hi (hi_src),
         .from_lo (lo_src),
         .par     (par_d[i]),
         .q_o     (q[i])
      );
   end

   // R1
   clear_zero_chk: assert property (@(posedge clk) !clr_n |-> q == '0);
   // R2
   hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
      ($past(clr_n) && $past({sel0, sel1}) == 2'b00) |-> q == $past(q));
   // R3
   right_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
      ($past(clr_n) && $past({sel0, sel1}) == 2'b10)
         |-> q == {$past(ser_rt), $past(q[MSB:1])});
   // R4
   left_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
      ($past(clr_n) && $past({sel0, sel1}) == 2'b01)
         |-> q == {$past(q[MSB-1:0]), $past(ser_lf)});
   // R5
   load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
      ($past(clr_n) && $past({sel0, sel1}) == 2'b11) |-> q == $past(par_d));
endmodule

// File: tb/tb_uni_shreg.sv
module tb_uni_shreg;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         clr_n = 1'b1;
   logic         sel0 = 1'b0, sel1 = 1'b0, ser_rt = 1'b0, ser_lf = 1'b0;
   logic [W-1:0] par_d = '0;
   logic [W-1:0] q;

   int checks = 0;
   int failures = 0;
   bit mdl[$];   // mdl[0] is QA, mdl[W-1] is QD

   uni_shreg #(.WIDTH(W)) dut (
      .clk(clk), .clr_n(clr_n), .sel0(sel0), .sel1(sel1),
      .ser_rt(ser_rt), .ser_lf(ser_lf), .par_d(par_d), .q(q)
   );

   always #10 clk = ~clk;

   function automatic logic [W-1:0] mdl_word();
      logic [W-1:0] w;
      for (int i = 0; i < W; i++) w[W-1-i] = mdl[i];
      return w;
   endfunction

   task automatic mdl_zero();
      mdl.delete();
      for (int i = 0; i < W; i++) mdl.push_back(1'b0);
   endtask

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: q=%b expected %b", req, act, exp);
      end
   endtask

   // drive on falling edge, apply at rising edge, compare at next falling edge
   task automatic step(bit s0, bit s1, bit sr, bit sl, logic [W-1:0] d, string req);
      sel0 = s0; sel1 = s1; ser_rt = sr; ser_lf = sl; par_d = d;
      @(posedge clk);
      case ({s0, s1})
         2'b10: begin mdl.push_front(sr); void'(mdl.pop_back()); end
         2'b01: begin void'(mdl.pop_front()); mdl.push_back(sl); end
         2'b11: for (int i = 0; i < W; i++) mdl[i] = d[W-1-i];
         default: ;
      endcase
      @(negedge clk);
      check(req, q, mdl_word());
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog: q=%b expected %b", q, mdl_word());
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      mdl_zero();
      #2 clr_n = 1'b0;
      #1 check("R1 reset", q, '0);
      @(negedge clk);
      clr_n = 1'b1;
      // R5 loads, R2 hold with noisy serial inputs
      step(1, 1, 0, 0, 4'b1011, "R5 load");
      step(0, 0, 1, 1, 4'b0000, "R2 hold");
      step(0, 0, 0, 1, 4'b1111, "R2 hold R7");
      step(1, 1, 1, 1, 4'b0101, "R5 load");
      // R3 right shifts, ser_lf toggled (R7)
      step(1, 0, 1, 0, 4'b0000, "R3 right");
      step(1, 0, 0, 1, 4'b1111, "R3 right R7");
      step(1, 0, 1, 1, 4'b0000, "R3 right");
      // R4 left shifts, ser_rt toggled (R7)
      step(0, 1, 1, 0, 4'b0000, "R4 left R7");
      step(0, 1, 0, 1, 4'b1010, "R4 left");
      step(0, 1, 1, 1, 4'b0000, "R4 left");
      step(0, 1, 0, 0, 4'b0000, "R4 left");
      // R6: mid-phase input changes must not reach q before the edge
      step(1, 1, 0, 0, 4'b1001, "R5 load");
      sel0 = 1'b1; sel1 = 1'b1; par_d = 4'b0110;
      #3 check("R6 no early change", q, 4'b1001);
      sel0 = 1'b1; sel1 = 1'b0; ser_rt = 1'b1;
      #3 check("R6 no early change", q, 4'b1001);
      step(0, 0, 0, 0, 4'b0000, "R2 hold after R6");
      // R8 rotate: preset 0110, QD fed to ser_rt
      step(1, 1, 0, 0, 4'b0110, "R8 preset");
      for (int k = 0; k < 8; k++) begin
         logic [W-1:0] expd;
         case (k % 4)
            0: expd = 4'b0011;
            1: expd = 4'b1001;
            2: expd = 4'b1100;
            default: expd = 4'b0110;
         endcase
         step(1, 0, q[0], 0, 4'b0000, "R8 rotate");
         check("R8 rotate sequence", q, expd);
      end
      // R1 async clear mid-phase with load selected
      step(1, 1, 0, 0, 4'b1111, "R5 load");
      sel0 = 1'b1; sel1 = 1'b1; par_d = 4'b1111;
      #4 clr_n = 1'b0;
      #1 check("R1 async clear", q, '0);
      @(posedge clk);
      @(negedge clk);
      check("R1 clear beats load", q, '0);
      mdl_zero();
      clr_n = 1'b1;
      step(1, 0, 1, 0, 4'b0000, "R3 right after R1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule